// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers twenty-four maskable interrupt lines from the peripherals of a small processor system and latches each incoming pulse into its own pending flag. The flags are qualified by per-source enable bits and one global enable. A fixed-order selector then chooses the lowest-numbered eligible source. That source is offered to the CPU core as a registered request together with its 16-bit vector address, which is 0x0003 plus eight times the source number.

Software programs the enables through a small register port. The port has four eight-bit registers, each carrying six source enables, and the first register also holds the global enable. The core answers a request with a one-cycle acknowledge. This clears the served flag and frees the controller to present the next candidate. A cycle in which an enable register is being written never raises a new request. The request is postponed to the following cycle and is not lost.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every pending flag, every enable bit and the global enable are 0, `cpu_req` is 0, and `cfg_rdata` reads 0 at every address.
- R2: The vector for source n is 0x0003 + 8*n (0x0003 for source 0, 0x00BB for source 23); the controller never outputs 0x0000 with a request.
- R3: Register map: address k (0..3) bits 0..5 enable sources 6k..6k+5; bit 7 of address 0 is the global enable; bit 6 of address 0 and bits 6..7 of addresses 1..3 ignore writes and read as 0.
- R4: A source is requested only while the global enable and its own enable bit are both 1.
- R5: A high cycle on `irq_in[n]` sets flag n whether or not source n is enabled; the flag is kept until served, and pulses that arrive while it is already set add no further service.
- R6: An acknowledge while `cpu_req` is high clears only the served flag and drops `cpu_req` in the next cycle; a pulse on the served line in the acknowledge cycle sets its flag again.
- R7: Among eligible flags the lowest source number is presented.
- R8: While `cpu_req` is high and unacknowledged, `cpu_req` and `cpu_vec` hold, even if a lower-numbered source becomes pending.
- R9: No request rises in a cycle with `cfg_we` high; an eligible source is presented in the next cycle without it.
- R10: A pulse on an enabled line sampled at edge k, with no request outstanding and no write, gives `cpu_req` high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_in | input | 24 | Interrupt pulses, one line per source, active high |
| cpu_req | output | 1 | Interrupt request to the core |
| cpu_vec | output | 16 | Vector address of the requested source |
| cpu_ack | input | 1 | Core accepts the request |

## Verification
A pulse sampled at one rising edge sets its flag at that edge, and the request with its vector appears after the next edge. The bench therefore drives on falling edges and samples two falling edges after the pulse starts. An acknowledge takes effect at the edge that samples it, so `cpu_req` is checked low at the falling edge right after it. Any next candidate is checked one falling edge later. A write postpones a request by exactly one edge, and the bench checks for the gap and then for the late request in the following cycle. Readback through `cfg_rdata` is combinational and is checked in the same cycle the address is set.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   // register selects on the configuration port
   typedef enum logic [1:0] {
      SEL_BANK0 = 2'd0,
      SEL_BANK1 = 2'd1,
      SEL_BANK2 = 2'd2,
      SEL_BANK3 = 2'd3
   } irq_sel_e;

   // vector address of a source: base plus stride times index
   function automatic int unsigned vec_of(input int unsigned base,
                                          input int unsigned stride,
                                          input int unsigned idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
   parameter int NUM_SRC     = 24,
   parameter int SRC_PER_REG = 6,
   parameter int REG_W       = 8,
   parameter int CFG_AW      = 2,
   parameter int GEN_BIT     = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CFG_AW-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   output logic [NUM_SRC-1:0]  src_en,
   output logic                glob_en
);
   localparam int NUM_REG = NUM_SRC / SRC_PER_REG;

   logic [SRC_PER_REG-1:0] bank_q [NUM_REG];
   logic                   glob_q;

   for (genvar r = 0; r < NUM_REG; r++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[r] <= '0;
         end else if (we && addr == CFG_AW'(r)) begin
            bank_q[r] <= wdata[SRC_PER_REG-1:0];
         end
      end
      assign src_en[r*SRC_PER_REG +: SRC_PER_REG] = bank_q[r];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= 1'b0;
      end else if (we && addr == CFG_AW'(0)) begin
         glob_q <= wdata[GEN_BIT];
      end
   end
   assign glob_en = glob_q;

   always_comb begin
      rdata = '0;
      for (int r = 0; r < NUM_REG; r++) begin
         if (addr == CFG_AW'(r)) rdata[SRC_PER_REG-1:0] = bank_q[r];
      end
      if (addr == CFG_AW'(0)) rdata[GEN_BIT] = glob_q;
   end

   // reserved data bits are never stored
   logic unused_wdata;
   assign unused_wdata = ^wdata;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_SRC = 24,
   parameter int IDX_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   output logic [NUM_SRC-1:0]  pend
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic flag_q;
      logic hit;
      assign hit = clr_en && (clr_idx == IDX_W'(i));
      // a new pulse wins over the clear of the same flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= (flag_q & ~hit) | irq_in[i];
      end
      assign pend[i] = flag_q;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 24,
   parameter int IDX_W   = 5
) (
   input  logic [NUM_SRC-1:0] elig,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);
   // fixed order: scanning downward leaves the lowest eligible index
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC     = 24,
   parameter int SRC_PER_REG = 6,
   parameter int REG_W       = 8,
   parameter int CFG_AW      = 2,
   parameter int GEN_BIT     = 7,
   parameter int VEC_W       = 16,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STRIDE  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [REG_W-1:0]    cfg_wdata,
   output logic [REG_W-1:0]    cfg_rdata,
   input  logic [NUM_SRC-1:0]  irq_in,
   output logic                cpu_req,
   output logic [VEC_W-1:0]    cpu_vec,
   input  logic                cpu_ack
);
   localparam int NUM_REG = NUM_SRC / SRC_PER_REG;
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_REG * SRC_PER_REG != NUM_SRC) begin : g_chk_split
      $error("NUM_SRC must be a multiple of SRC_PER_REG");
   end
   if ((1 << CFG_AW) < NUM_REG) begin : g_chk_addr
      $error("CFG_AW too narrow for the enable registers");
   end
   if (GEN_BIT < SRC_PER_REG || GEN_BIT >= REG_W) begin : g_chk_gen
      $error("GEN_BIT must sit above the source enables");
   end
   if (VEC_BASE + VEC_STRIDE * (NUM_SRC - 1) >= (1 << VEC_W)) begin : g_chk_vec
      $error("VEC_W too narrow for the last vector");
   end

   logic [NUM_SRC-1:0] src_en_w;
   logic               glob_en_w;
   logic [NUM_SRC-1:0] pend_w;
   logic [NUM_SRC-1:0] elig_w;
   logic               found_w;
   logic [IDX_W-1:0]   pick_w;

   logic               req_q;
   logic [IDX_W-1:0]   idx_q;
   logic [VEC_W-1:0]   vec_q;
   logic               served;

   irq_enable_regs #(
      .NUM_SRC(NUM_SRC), .SRC_PER_REG(SRC_PER_REG), .REG_W(REG_W),
      .CFG_AW(CFG_AW), .GEN_BIT(GEN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .src_en(src_en_w), .glob_en(glob_en_w)
   );

   assign served = req_q & cpu_ack;

   irq_pend_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .clr_en(served), .clr_idx(idx_q), .pend(pend_w)
   );

   assign elig_w = pend_w & src_en_w & {NUM_SRC{glob_en_w}};

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .elig(elig_w), .found(found_w), .idx(pick_w)
   );

   // request handshake: latch index and vector on raise, hold to ack
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         vec_q <= '0;
      end else if (!req_q) begin
         if (found_w && !cfg_we) begin
            req_q <= 1'b1;
            idx_q <= pick_w;
            vec_q <= VEC_W'(vec_of(VEC_BASE, VEC_STRIDE, int'(pick_w)));
         end
      end else if (cpu_ack) begin
         req_q <= 1'b0;
      end
   end

   assign cpu_req = req_q;
   assign cpu_vec = vec_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int NUM_SRC = 24,
   parameter int IDX_W   = 5,
   parameter int VEC_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [NUM_SRC-1:0] irq_in,
   input logic               cpu_req,
   input logic               cpu_ack,
   input logic [VEC_W-1:0]   cpu_vec,
   input logic [NUM_SRC-1:0] pend,
   input logic [IDX_W-1:0]   idx,
   input logic               glob_en,
   input logic [NUM_SRC-1:0] src_en
);
   logic [NUM_SRC-1:0] pend_d, en_d, below;
   logic               glob_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_d <= '0;
         en_d   <= '0;
         glob_d <= 1'b0;
      end else begin
         pend_d <= pend;
         en_d   <= src_en;
         glob_d <= glob_en;
      end
   end

   assign below = (NUM_SRC'(1) << idx) - NUM_SRC'(1);

   a_r4_gated_raise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_req) |-> glob_d && en_d[idx] && pend_d[idx]);

   a_r5_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in != '0) |=> ((pend & $past(irq_in)) == $past(irq_in)));

   a_r6_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ack |=> !cpu_req);

   a_r6_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ack && !irq_in[idx] |=> !pend[$past(idx)]);

   a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_req) |-> ((pend_d & en_d & {NUM_SRC{glob_d}} & below) == '0));

   a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_ack |=> cpu_req && $stable(cpu_vec));

   a_r9_write_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req && cfg_we |=> !cpu_req);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .irq_in(irq_in),
   .cpu_req(cpu_req), .cpu_ack(cpu_ack), .cpu_vec(cpu_vec),
   .pend(pend_w), .idx(idx_q), .glob_en(glob_en_w), .src_en(src_en_w)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [23:0] irq_in = '0;
   logic        cpu_req;
   logic [15:0] cpu_vec;
   logic        cpu_ack = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
      .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
   );

   // source index and expected vector, one entry per bank edge
   localparam logic [20:0] TBL [8] = '{
      {5'd0,  16'h0003}, {5'd5,  16'h002B}, {5'd6,  16'h0033},
      {5'd11, 16'h005B}, {5'd12, 16'h0063}, {5'd17, 16'h008B},
      {5'd18, 16'h0093}, {5'd23, 16'h00BB}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
      cfg_addr = a;
      #1;
      chk(tag, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic pulse(input logic [23:0] m);
      @(negedge clk);
      irq_in = m;
      @(negedge clk);
      irq_in = '0;
   endtask

   task automatic ack();
      cpu_ack = 1'b1;
      @(negedge clk);
      cpu_ack = 1'b0;
   endtask

   task automatic expect_req(input string tag, input logic [15:0] v);
      chk({tag, " req"}, 32'(cpu_req), 32'd1);
      chk({tag, " vec"}, 32'(cpu_vec), 32'(v));
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 req after reset", 32'(cpu_req), 32'd0);
      for (int a = 0; a < 4; a++) rd("R1 rdata after reset", 2'(a), 8'h00);
      pulse(24'h000001); step(); step();
      chk("R1 all disabled no req", 32'(cpu_req), 32'd0);

      // R3 register map and reserved bits
      wr(2'd0, 8'hFF); rd("R3 bank0 readback", 2'd0, 8'hBF);
      wr(2'd1, 8'hFF); rd("R3 bank1 readback", 2'd1, 8'h3F);
      wr(2'd2, 8'hFF); rd("R3 bank2 readback", 2'd2, 8'h3F);
      wr(2'd3, 8'hFF); rd("R3 bank3 readback", 2'd3, 8'h3F);
      // flag of source 0 set while disabled is now served (R5)
      step();
      expect_req("R5 late enable src0", 16'h0003);
      ack();
      chk("R6 req drops after ack", 32'(cpu_req), 32'd0);

      // table walk: R2 vector formula, R10 latency
      for (int t = 0; t < 8; t++) begin
         pulse(24'(1) << TBL[t][20:16]);
         step();
         expect_req("R10 R2 table", TBL[t][15:0]);
         ack();
         chk("R6 table ack", 32'(cpu_req), 32'd0);
      end

      // R4 global enable off holds the request
      wr(2'd0, 8'h3F);
      pulse(24'h000004); step(); step(); step();
      chk("R4 global off", 32'(cpu_req), 32'd0);
      wr(2'd0, 8'hBF);
      step();
      expect_req("R4 global on", 16'h0013);
      ack();
      // R4 own enable off
      wr(2'd0, 8'hBB);
      pulse(24'h000004); step(); step(); step();
      chk("R4 source off", 32'(cpu_req), 32'd0);
      wr(2'd0, 8'hBF);
      step();
      expect_req("R4 source on", 16'h0013);
      ack();

      // R5 repeated pulses give one service
      wr(2'd0, 8'h3F);
      pulse(24'h000010); pulse(24'h000010);
      wr(2'd0, 8'hBF);
      step();
      expect_req("R5 double pulse", 16'h0023);
      ack(); step(); step(); step();
      chk("R5 served once", 32'(cpu_req), 32'd0);

      // R7 fixed priority, R6 other flags kept
      pulse((24'(1) << 20) | (24'(1) << 9) | (24'(1) << 15));
      step();
      expect_req("R7 first", 16'h004B);
      ack(); step();
      expect_req("R7 R6 second", 16'h007B);
      ack(); step();
      expect_req("R7 R6 third", 16'h00A3);
      ack(); step();
      chk("R7 drained", 32'(cpu_req), 32'd0);

      // R8 vector held while a lower source arrives
      pulse(24'(1) << 10);
      step();
      expect_req("R8 initial", 16'h0053);
      pulse(24'h000001); step(); step();
      expect_req("R8 held", 16'h0053);
      ack(); step();
      expect_req("R8 then lower", 16'h0003);
      ack();

      // R9 write cycle postpones the raise
      @(negedge clk); irq_in = 24'(1) << 7;
      @(negedge clk); irq_in = '0;
      cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h3F;
      @(negedge clk); cfg_we = 1'b0;
      chk("R9 suppressed", 32'(cpu_req), 32'd0);
      step();
      expect_req("R9 delayed", 16'h003B);
      ack();

      // R6 pulse in the ack cycle re-arms the flag
      pulse(24'h000002);
      step();
      expect_req("R6 first", 16'h000B);
      cpu_ack = 1'b1; irq_in = 24'h000002;
      @(negedge clk);
      cpu_ack = 1'b0; irq_in = '0;
      chk("R6 ack drop", 32'(cpu_req), 32'd0);
      step();
      expect_req("R6 re-armed", 16'h000B);
      ack();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule